// File: doc/BRIEF.md
# Multi-Mode 24-Bit Counter Channel

This block is one channel of a general-purpose counter/timer. A host reaches it through four 16-bit word registers: the low count word, the high count word, a packed mode word and a write-only command word. The channel counts quadrature encoder phases at one, two or four counts per encoder cycle, or an internal clock strobe, up or down. The direction comes either from the phase relationship or from a software bit.

Two preload registers feed the counter. Software can reset or load the count by command, and a rising index edge can reload it automatically. A capture flag (the catch flag) is set when a down-count reaches zero and is cleared by command. The catch flag can gate the counter, so one command fires a single timed pulse on the output pin. The output pin shows either the catch flag or a zero-count flag, with selectable polarity.

A 24-bit value is read coherently: a read of the low word takes a snapshot of the whole count, and the next high-word read returns bits from that snapshot.

Top module: `cnt24_channel`

## Requirements
- R1: After synchronous reset, the count, both preloads and the mode word are zero, the catch flag is 1, `quad_err` is 0 and `bus_rdata` is 0.
- R2: Word select is `bus_addr[2:1]`: 0 low count, 1 high count, 2 mode, 3 command. A mode read returns the last value written to it, and a command read returns 0. Read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read.
- R3: Writes to the low or high word go to preload 1 when mode bit 14 is 1, and to preload 0 when it is 0. A high-word write keeps only `wdata[7:0]`, as count bits 23:16. A command write with bit 14 set loads the count from preload 0, and one with bit 15 set clears the count; bit 14 wins when both are set.
- R4: With mode bit 13 at 0, a low-word read captures the whole count, and a later high-word read returns bits 23:16 of that capture in `rdata[7:0]`, with zeros above. With bit 13 at 1, a high-word read returns the live count bits.
- R5: Mode bits 10:9 select the clock. Value 0 gives one count per encoder cycle, on A rising while B is low (A falling while B is low going back). Value 1 counts every A edge. Value 2 counts every legal phase change. Phase A leading B (00, 10, 11, 01) is the up direction.
- R6: Mode bit 12 at 0 takes direction from the phases. At 1 it takes direction from mode bit 11 (0 up, 1 down). Clock value 3 counts each cycle that `tick` is high, always in the bit-11 direction.
- R7: A phase change where both A and B flip at once does not move the count. It sets `quad_err`, which stays set until reset.
- R8: Mode bits 8:7 select the enable: 0 off, 1 always on, 2 or 3 gated by the source in bits 6:5 (0 `gate`, 1 inverted `gate`, 2 catch flag, 3 inverted catch flag).
- R9: When mode bits 4:2 equal 4, a rising `idx` edge loads the count from the preload selected by bit 14. When they equal 0, `idx` has no effect.
- R10: The catch flag sets when a down step makes the count zero, and clears on a command write with bit 3 set. `cnt_out` is the catch flag (mode bit 0 = 0) or the count-is-zero flag (bit 0 = 1), inverted when mode bit 1 is 1.
- R11: The count wraps modulo 2^24 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Byte offset within the channel |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pha | input | 1 | Encoder phase A (asynchronous) |
| phb | input | 1 | Encoder phase B (asynchronous) |
| idx | input | 1 | Encoder index (asynchronous) |
| tick | input | 1 | Internal clock strobe |
| gate | input | 1 | Hardware enable pin |
| cnt_out | output | 1 | Counter output pin |
| quad_err | output | 1 | Sticky illegal-transition flag |

## Verification
The bench reads a count word while the counter steps over a 16-bit carry. A design without a coherent snapshot would return a high byte one larger than the low word implies. It drives full encoder cycles at each decode rate, including reversals and a double-phase jump. A wrong decoder would count at the wrong multiple, miscount the reversal, or step on the jump without raising `quad_err`. It fires a one-shot from a known preload. A design with the wrong gate polarity or catch-flag rule would either never start or run past zero and wrap. It also checks that index reload uses the selected preload and is ignored with auto-load off.

// File: rtl/cnt24_pkg.sv
package cnt24_pkg;

    localparam int CNT_W      = 24;
    localparam int BUS_W      = 16;
    localparam int HI_W       = CNT_W - BUS_W;
    localparam int PRE_COUNT  = 2;
    localparam int PRE_SEL_W  = $clog2(PRE_COUNT);

    localparam int CMD_CLEAR_BIT = 15;
    localparam int CMD_LOAD_BIT  = 14;
    localparam int CMD_UNCAP_BIT = 3;

    localparam logic [2:0] RELOAD_OFF   = 3'd0;
    localparam logic [2:0] RELOAD_INDEX = 3'd4;

    typedef enum logic [1:0] {
        WSEL_LOW  = 2'd0,
        WSEL_HIGH = 2'd1,
        WSEL_MODE = 2'd2,
        WSEL_CMD  = 2'd3
    } word_sel_e;

    typedef enum logic [1:0] {
        CLK_QX1 = 2'd0,
        CLK_QX2 = 2'd1,
        CLK_QX4 = 2'd2,
        CLK_INT = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        GATE_PIN   = 2'd0,
        GATE_PIN_N = 2'd1,
        GATE_CAP   = 2'd2,
        GATE_CAP_N = 2'd3
    } gate_src_e;

    // Mode word, MSB first; bit positions are decoded by the bus.
    typedef struct packed {
        logic       spare;      // 15
        logic       pre_sel;    // 14
        logic       live_read;  // 13
        logic       dir_sw;     // 12
        logic       dir_down;   // 11
        clk_src_e   clk_src;    // 10:9
        logic [1:0] en_ctl;     // 8:7
        gate_src_e  gate_src;   // 6:5
        logic [2:0] reload;     // 4:2
        logic       out_inv;    // 1
        logic       out_zero;   // 0
    } mode_t;

    typedef struct packed {
        logic valid;
        logic down;
    } step_t;

    function automatic logic gate_level(gate_src_e src, logic pin, logic cap);
        case (src)
            GATE_PIN:   return pin;
            GATE_PIN_N: return !pin;
            GATE_CAP:   return cap;
            default:    return !cap;
        endcase
    endfunction

endpackage

// File: rtl/cnt24_quad.sv
module cnt24_quad
    import cnt24_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pha,
    input  logic     phb,
    input  logic     idx,
    input  clk_src_e rate,
    output step_t    qstep,
    output logic     idx_rise,
    output logic     err
);

    logic [SYNC_DEPTH-1:0] sync_a, sync_b, sync_i;
    logic a_now, b_now, i_now;
    logic a_old, b_old, i_old;
    logic a_chg, b_chg, legal, jump;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= '0;
            sync_b <= '0;
            sync_i <= '0;
            a_old  <= 1'b0;
            b_old  <= 1'b0;
            i_old  <= 1'b0;
            err    <= 1'b0;
        end else begin
            sync_a <= {sync_a[SYNC_DEPTH-2:0], pha};
            sync_b <= {sync_b[SYNC_DEPTH-2:0], phb};
            sync_i <= {sync_i[SYNC_DEPTH-2:0], idx};
            a_old  <= a_now;
            b_old  <= b_now;
            i_old  <= i_now;
            err    <= err | jump;
        end
    end

    assign a_now = sync_a[SYNC_DEPTH-1];
    assign b_now = sync_b[SYNC_DEPTH-1];
    assign i_now = sync_i[SYNC_DEPTH-1];

    assign a_chg = a_now ^ a_old;
    assign b_chg = b_now ^ b_old;
    assign legal = a_chg ^ b_chg;
    assign jump  = a_chg & b_chg;

    assign idx_rise = i_now & ~i_old;

    always_comb begin
        qstep.down = a_chg ? (a_now == b_now) : (a_now != b_now);
        case (rate)
            CLK_QX1: qstep.valid = legal & a_chg & ~b_now;
            CLK_QX2: qstep.valid = legal & a_chg;
            CLK_QX4: qstep.valid = legal;
            default: qstep.valid = 1'b0;
        endcase
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(err) |-> err);  // R7

    AST_JUMP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        $past(jump) |-> err);  // R7

endmodule

// File: rtl/cnt24_core.sv
module cnt24_core
    import cnt24_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  mode_t            mode,
    input  logic [BUS_W-1:0] wdata,
    input  logic             pre_wr_lo,
    input  logic             pre_wr_hi,
    input  logic             cmd_clear,
    input  logic             cmd_load,
    input  logic             cmd_uncap,
    input  step_t            qstep,
    input  logic             tick,
    input  logic             idx_rise,
    input  logic             gate,
    output logic [CNT_W-1:0] count,
    output logic             cap
);

    logic [CNT_W-1:0] pre [PRE_COUNT];
    logic [CNT_W-1:0] nxt;
    logic             en, stp, down, adv, idx_load;

    for (genvar p = 0; p < PRE_COUNT; p++) begin : g_pre
        localparam logic [PRE_SEL_W-1:0] SEL = PRE_SEL_W'(p);
        always_ff @(posedge clk) begin
            if (rst) begin
                pre[p] <= '0;
            end else if (mode.pre_sel == SEL) begin
                if (pre_wr_lo) pre[p][BUS_W-1:0]     <= wdata;
                if (pre_wr_hi) pre[p][CNT_W-1:BUS_W] <= wdata[HI_W-1:0];
            end
        end
    end

    always_comb begin
        en = (mode.en_ctl == 2'd1) ||
             (mode.en_ctl[1] && gate_level(mode.gate_src, gate, cap));
        if (mode.clk_src == CLK_INT) begin
            stp  = tick;
            down = mode.dir_down;
        end else begin
            stp  = qstep.valid;
            down = mode.dir_sw ? mode.dir_down : qstep.down;
        end
        adv      = stp & en;
        nxt      = down ? count - CNT_W'(1) : count + CNT_W'(1);
        idx_load = (mode.reload == RELOAD_INDEX) && idx_rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            cap   <= 1'b1;
        end else begin
            if (cmd_load) begin
                count <= pre[0];
            end else if (cmd_clear) begin
                count <= '0;
            end else if (idx_load) begin
                count <= pre[mode.pre_sel];
            end else if (adv) begin
                count <= nxt;
                if (down && nxt == '0) cap <= 1'b1;
            end
            if (cmd_uncap) cap <= 1'b0;
        end
    end

    logic unused_fields;
    assign unused_fields = ^{mode.spare, mode.live_read, mode.out_inv, mode.out_zero};

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        !$past(cmd_load || cmd_clear || idx_load) |->
        (count == $past(count) || count == $past(count) + CNT_W'(1) ||
         count == $past(count) - CNT_W'(1)));  // R11

    AST_CLEAR_CMD: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_clear && !cmd_load) |-> count == '0);  // R3

    AST_UNCAP_CMD: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_uncap) |-> !cap);  // R10

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        $past(!en && !cmd_load && !cmd_clear && !idx_load) |-> count == $past(count));  // R8

endmodule

// File: rtl/cnt24_channel.sv
module cnt24_channel
    import cnt24_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        pha,
    input  logic        phb,
    input  logic        idx,
    input  logic        tick,
    input  logic        gate,
    output logic        cnt_out,
    output logic        quad_err
);

    word_sel_e        sel;
    mode_t            mode;
    step_t            qstep;
    logic             idx_rise;
    logic [CNT_W-1:0] count;
    logic             cap;
    logic [HI_W-1:0]  snap_hi;
    logic             wr_cmd;

    assign sel    = word_sel_e'(bus_addr[2:1]);
    assign wr_cmd = bus_wr && sel == WSEL_CMD;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else if (bus_wr && sel == WSEL_MODE) begin
            mode <= mode_t'(bus_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            snap_hi   <= '0;
        end else if (bus_rd) begin
            case (sel)
                WSEL_LOW: begin
                    bus_rdata <= count[BUS_W-1:0];
                    snap_hi   <= count[CNT_W-1:BUS_W];
                end
                WSEL_HIGH: bus_rdata <= {{(BUS_W-HI_W){1'b0}},
                                         mode.live_read ? count[CNT_W-1:BUS_W] : snap_hi};
                WSEL_MODE: bus_rdata <= mode;
                default:   bus_rdata <= '0;
            endcase
        end
    end

    cnt24_quad #(.SYNC_DEPTH(SYNC_DEPTH)) u_quad (
        .clk      (clk),
        .rst      (rst),
        .pha      (pha),
        .phb      (phb),
        .idx      (idx),
        .rate     (mode.clk_src),
        .qstep    (qstep),
        .idx_rise (idx_rise),
        .err      (quad_err)
    );

    cnt24_core u_core (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .wdata     (bus_wdata),
        .pre_wr_lo (bus_wr && sel == WSEL_LOW),
        .pre_wr_hi (bus_wr && sel == WSEL_HIGH),
        .cmd_clear (wr_cmd && bus_wdata[CMD_CLEAR_BIT]),
        .cmd_load  (wr_cmd && bus_wdata[CMD_LOAD_BIT]),
        .cmd_uncap (wr_cmd && bus_wdata[CMD_UNCAP_BIT]),
        .qstep     (qstep),
        .tick      (tick),
        .idx_rise  (idx_rise),
        .gate      (gate),
        .count     (count),
        .cap       (cap)
    );

    assign cnt_out = (mode.out_zero ? (count == '0) : cap) ^ mode.out_inv;

    logic unused_addr;
    assign unused_addr = bus_addr[0];

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> $stable(bus_rdata));  // R2

    AST_HIGH_PADDED: assert property (@(posedge clk) disable iff (rst)
        $past(bus_rd && sel == WSEL_HIGH) |-> bus_rdata[BUS_W-1:HI_W] == '0);  // R4

endmodule

// File: tb/test_cnt24_channel.sv
module test_cnt24_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0, rd = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        pha = 1'b0, phb = 1'b0, idx = 1'b0, tick = 1'b0, gate = 1'b0;
    logic        cnt_out, quad_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int pos = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #4 clk = ~clk;

    cnt24_channel i_cnt24_channel (
        .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .pha(pha), .phb(phb), .idx(idx),
        .tick(tick), .gate(gate), .cnt_out(cnt_out), .quad_err(quad_err)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares each read result against the scoreboard queue.
    always @(posedge clk) rd_seen <= rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("scoreboard unexpected read", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), {16'h0, rdata}, {16'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(logic [2:0] a, logic [15:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(logic [2:0] a, logic [15:0] e, string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic rd_count(logic [23:0] v, string t);
        rd_reg(3'd0, v[15:0], t);
        rd_reg(3'd2, {8'h00, v[23:16]}, t);
    endtask

    task automatic set_phase();
        pha = (pos == 1) || (pos == 2);
        phb = (pos == 2) || (pos == 3);
        idle(4);
    endtask

    task automatic qmove(bit up, int n);
        for (int i = 0; i < n; i++) begin
            pos = up ? (pos + 1) % 4 : (pos + 3) % 4;
            set_phase();
        end
    endtask

    task automatic ticks(int n);
        tick = 1'b1;
        idle(n);
        tick = 1'b0;
        idle(1);
    endtask

    task automatic index_pulse();
        idx = 1'b1;
        idle(4);
        idx = 1'b0;
        idle(4);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        check("R1 rdata after reset", {16'h0, rdata}, 32'h0);
        rd_count(24'h0, "R1 count after reset");
        rd_reg(3'd4, 16'h0000, "R1 mode after reset");
        check("R1 quad_err after reset", {31'h0, quad_err}, 32'h0);
        check("R1 catch flag set, output high", {31'h0, cnt_out}, 32'h1);

        // R2 register map and mode readback
        rd_reg(3'd6, 16'h0000, "R2 command reads zero");
        wr_reg(3'd4, 16'h2C35);
        rd_reg(3'd4, 16'h2C35, "R2 mode readback");
        wr_reg(3'd4, 16'h0000);

        // R3 preload select, high byte mask, commands
        wr_reg(3'd0, 16'h5678);
        wr_reg(3'd2, 16'hFF12);
        wr_reg(3'd4, 16'h4000);
        wr_reg(3'd0, 16'hBEEF);
        wr_reg(3'd2, 16'h00AB);
        wr_reg(3'd4, 16'h0000);
        wr_reg(3'd6, 16'h4000);
        rd_count(24'h125678, "R3 load from preload 0");
        wr_reg(3'd6, 16'h8000);
        rd_count(24'h000000, "R3 clear command");
        wr_reg(3'd6, 16'hC000);
        rd_count(24'h125678, "R3 load beats clear");
        wr_reg(3'd6, 16'h8000);

        // R4 coherent snapshot across a 16-bit carry
        wr_reg(3'd0, 16'hFFFF);
        wr_reg(3'd2, 16'h0001);
        wr_reg(3'd6, 16'h4000);
        wr_reg(3'd4, 16'h1680);
        exp_q.push_back(16'hFFFF);
        tag_q.push_back("R4 low word at snapshot");
        rd = 1'b1; addr = 3'd0; tick = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        idle(5);
        tick = 1'b0;
        rd_reg(3'd2, 16'h0001, "R4 high word from snapshot");
        wr_reg(3'd4, 16'h3680);
        rd_reg(3'd2, 16'h0002, "R4 live high word");
        rd_reg(3'd0, 16'h0005, "R4 low word after six ticks");

        // R5 decode rates, R6 direction
        wr_reg(3'd4, 16'h0480);
        wr_reg(3'd6, 16'h8000);
        qmove(1, 8);
        rd_count(24'd8, "R5 x4 up");
        qmove(0, 3);
        rd_count(24'd5, "R6 x4 phase reversal counts down");
        wr_reg(3'd4, 16'h0280);
        wr_reg(3'd6, 16'h8000);
        qmove(1, 8);
        rd_count(24'd4, "R5 x2 up");
        wr_reg(3'd4, 16'h0080);
        wr_reg(3'd6, 16'h8000);
        qmove(1, 8);
        rd_count(24'd2, "R5 x1 up");
        qmove(0, 4);
        rd_count(24'd1, "R5 x1 down");
        wr_reg(3'd4, 16'h1C80);
        wr_reg(3'd6, 16'h8000);
        qmove(1, 4);
        rd_count(24'hFFFFFC, "R6 software down overrides phase, R11 wrap");

        // R7 illegal jump
        wr_reg(3'd4, 16'h0480);
        wr_reg(3'd6, 16'h8000);
        pos = (pos + 2) % 4;
        set_phase();
        rd_count(24'd0, "R7 double flip ignored");
        check("R7 quad_err raised", {31'h0, quad_err}, 32'h1);
        qmove(1, 2);
        rd_count(24'd2, "R7 legal steps after jump");
        check("R7 quad_err sticky", {31'h0, quad_err}, 32'h1);

        // R8 enable and gating
        gate = 1'b0;
        wr_reg(3'd4, 16'h1700);
        wr_reg(3'd6, 16'h8000);
        ticks(5);
        rd_count(24'd0, "R8 gate low blocks");
        gate = 1'b1;
        ticks(5);
        rd_count(24'd5, "R8 gate high counts");
        wr_reg(3'd4, 16'h1720);
        ticks(3);
        rd_count(24'd5, "R8 inverted gate blocks");
        wr_reg(3'd4, 16'h1600);
        ticks(4);
        rd_count(24'd5, "R8 enable off");
        gate = 1'b0;

        // R9 index auto-load
        wr_reg(3'd4, 16'h4010);
        wr_reg(3'd6, 16'h8000);
        index_pulse();
        rd_count(24'hABBEEF, "R9 index loads preload 1");
        wr_reg(3'd4, 16'h0010);
        index_pulse();
        rd_count(24'h01FFFF, "R9 index loads selected preload 0");
        wr_reg(3'd4, 16'h4000);
        wr_reg(3'd6, 16'h8000);
        index_pulse();
        rd_count(24'd0, "R9 auto-load off ignores index");

        // R10 one-shot
        wr_reg(3'd4, 16'h0000);
        wr_reg(3'd0, 16'h0005);
        wr_reg(3'd2, 16'h0000);
        wr_reg(3'd6, 16'h4000);
        wr_reg(3'd4, 16'h1F62);
        tick = 1'b1;
        idle(2);
        check("R10 armed output low", {31'h0, cnt_out}, 32'h0);
        rd_count(24'd5, "R10 held before firing");
        wr_reg(3'd6, 16'h0008);
        check("R10 pulse active after clear", {31'h0, cnt_out}, 32'h1);
        idle(10);
        check("R10 pulse ended", {31'h0, cnt_out}, 32'h0);
        rd_count(24'd0, "R10 stops at zero");
        tick = 1'b0;
        wr_reg(3'd4, 16'h0001);
        check("R10 zero-flag output", {31'h0, cnt_out}, 32'h1);
        wr_reg(3'd4, 16'h0003);
        check("R10 zero-flag output inverted", {31'h0, cnt_out}, 32'h0);

        idle(3);
        check("scoreboard drained", exp_q.size(), 32'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule